// File: doc/BRIEF.md
# Framing Clock and Periodic Interrupt Timer

This block is a free-running binary divider. It is advanced by a one-cycle enable that marks each bus-clock period. A single counter feeds two consumers. The first is a square-wave framing clock, which tells a display controller when to fetch its next subframe. The second is an active-low periodic interrupt request to a processor.

The request is raised when the interrupt stage of the counter first turns on after a restart. It stays asserted until software acknowledges it. To acknowledge, software drives a control bit high, which holds the whole divider at zero, and then drives it low, which lets counting start again from zero. The framing clock comes from the same counter, so every acknowledge also re-phases it.

With the default parameters the framing clock has a period of 1024 enabled cycles. The request falls 4096 enabled cycles after each restart, which is about 3.3 ms for a 1.25 MHz bus clock.

Top module: `frame_irq_timer`

## Requirements
- R1: While `rst` is high, the divider is cleared at each clock edge. From the edge after `rst` is seen high, `frame_clk` is 0 and `irq_n` is 1. This includes the case where `irq_n` was low before the reset.
- R2: The divider advances by exactly one on each clock edge where `e_en` is 1 and neither `rst` nor `ack_hold` is high. On edges where `e_en` is 0, neither output changes.
- R3: `frame_clk` is bit 9 of the divider count. It is 0 for counts whose value modulo 1024 is 0 to 511, and 1 for counts whose value modulo 1024 is 512 to 1023. This gives a 50% duty square wave with a period of 1024 enabled cycles.
- R4: `irq_n` goes low on the edge where the count reaches 4096, which is when bit 12 first turns on after a restart. At a count of 4095 it is still high.
- R5: Once low, `irq_n` stays low until `rst` or `ack_hold` is seen. This holds even when the 13-bit count wraps from 8191 to 0 and rises to 4096 again. Meanwhile `frame_clk` keeps toggling.
- R6: While `ack_hold` is 1, the divider is cleared at each edge whatever the value of `e_en`. From the next edge, `frame_clk` is 0 and `irq_n` is 1.
- R7: After `ack_hold` returns to 0, counting restarts from zero. `frame_clk` first rises 512 enabled cycles later, and `irq_n` falls 4096 enabled cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| e_en | input | 1 | One-cycle enable marking each bus-clock period |
| ack_hold | input | 1 | Software acknowledge bit; high holds the divider at zero |
| frame_clk | output | 1 | Display framing square wave |
| irq_n | output | 1 | Periodic interrupt request, active low, sticky |

## Verification
The bench probes the exact edges on both sides of each framing transition, and of the interrupt at counts 4095 and 4096. A divider tapped at the wrong bit, or an off-by-one in the count, shows up there as an early or late transition.

It lets the count wrap past 8191 while the request is pending. A request built as a pulse or a level copy of bit 12 would then go back high.

It holds the acknowledge bit across hundreds of enabled cycles, including cycles where the enable is low. A design that gates the clear with the enable, or that resumes from the old phase, would show a high framing clock or a late first rise.

It also alternates the enable to confirm that only enabled cycles count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Divider action chosen for one clock edge
    typedef enum logic [1:0] {
        DIV_HOLD    = 2'd0,
        DIV_ADVANCE = 2'd1,
        DIV_CLEAR   = 2'd2
    } div_ctl_e;

    // Observable outputs carried together
    typedef struct packed {
        logic frame;
        logic req_pend;
    } tmr_out_t;

    // Clearing beats advancing; the acknowledge bit clears regardless of the enable
    function automatic div_ctl_e ctl_decode(input logic rst, input logic ack, input logic en);
        if (rst || ack)
            return DIV_CLEAR;
        else if (en)
            return DIV_ADVANCE;
        else
            return DIV_HOLD;
    endfunction

    // A stage turns on when it is low now and high after the update
    function automatic logic stage_turns_on(input logic now_v, input logic next_v);
        return (!now_v) && next_v;
    endfunction

endpackage

// File: rtl/tmr_div_counter.sv
module tmr_div_counter #(
    parameter int W         = 13,
    parameter int FRAME_TAP = 9,
    parameter int IRQ_TAP   = 12
) (
    input  logic               clk,
    input  tmr_pkg::div_ctl_e  ctl,
    output logic               frame_q,
    output logic               irq_stage_q,
    output logic               irq_stage_nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nxt;

    always_comb begin
        unique case (ctl)
            tmr_pkg::DIV_CLEAR:   cnt_nxt = '0;
            tmr_pkg::DIV_ADVANCE: cnt_nxt = cnt_q + ONE;
            default:              cnt_nxt = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_nxt;
    end

    assign frame_q       = cnt_q[FRAME_TAP];
    assign irq_stage_q   = cnt_q[IRQ_TAP];
    assign irq_stage_nxt = cnt_nxt[IRQ_TAP];
endmodule

// File: rtl/tmr_req_latch.sv
module tmr_req_latch (
    input  logic               clk,
    input  tmr_pkg::div_ctl_e  ctl,
    input  logic               stage_q,
    input  logic               stage_nxt,
    output logic               pend_q
);
    logic set_req;

    assign set_req = (ctl == tmr_pkg::DIV_ADVANCE) &&
                     tmr_pkg::stage_turns_on(stage_q, stage_nxt);

    always_ff @(posedge clk) begin
        if (ctl == tmr_pkg::DIV_CLEAR)
            pend_q <= 1'b0;
        else if (set_req)
            pend_q <= 1'b1;
    end
endmodule

// File: rtl/frame_irq_timer.sv
module frame_irq_timer #(
    parameter int FRAME_LOG2 = 10,
    parameter int IRQ_LOG2   = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic e_en,
    input  logic ack_hold,
    output logic frame_clk,
    output logic irq_n
);
    import tmr_pkg::*;

    localparam int CNT_W     = IRQ_LOG2;
    localparam int FRAME_TAP = FRAME_LOG2 - 1;
    localparam int IRQ_TAP   = IRQ_LOG2 - 1;

    div_ctl_e ctl;
    tmr_out_t outs;
    logic     irq_stage_q;
    logic     irq_stage_nxt;

    assign ctl = ctl_decode(rst, ack_hold, e_en);

    generate
        if (FRAME_LOG2 < 1 || FRAME_LOG2 > IRQ_LOG2) begin : g_bad_cfg
            initial $error("frame divider stage must lie inside the counter");
        end
    endgenerate

    tmr_div_counter #(
        .W         (CNT_W),
        .FRAME_TAP (FRAME_TAP),
        .IRQ_TAP   (IRQ_TAP)
    ) u_cnt (
        .clk           (clk),
        .ctl           (ctl),
        .frame_q       (outs.frame),
        .irq_stage_q   (irq_stage_q),
        .irq_stage_nxt (irq_stage_nxt)
    );

    tmr_req_latch u_req (
        .clk       (clk),
        .ctl       (ctl),
        .stage_q   (irq_stage_q),
        .stage_nxt (irq_stage_nxt),
        .pend_q    (outs.req_pend)
    );

    assign frame_clk = outs.frame;
    assign irq_n     = ~outs.req_pend;
endmodule

// File: rtl/frame_irq_timer_chk.sv
module frame_irq_timer_chk (
    input logic clk,
    input logic rst,
    input logic e_en,
    input logic ack_hold,
    input logic frame_clk,
    input logic irq_n
);
    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ack_hold |=> (!frame_clk && irq_n));

    // R5
    req_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !ack_hold) |=> !irq_n);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!e_en && !ack_hold) |=> ($stable(frame_clk) && $stable(irq_n)));

    // R4
    req_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_n) |-> (!frame_clk && $past(e_en)));

    // R3
    frame_moves_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_clk) |-> ($past(e_en) && !$past(ack_hold)));
endmodule

bind frame_irq_timer frame_irq_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .e_en      (e_en),
    .ack_hold  (ack_hold),
    .frame_clk (frame_clk),
    .irq_n     (irq_n)
);

// File: tb/tb_frame_irq_timer.sv
`timescale 1ns/1ps
module tb_frame_irq_timer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic e_en = 1'b1;
    logic ack_hold = 1'b0;
    logic frame_clk;
    logic irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    frame_irq_timer dut (
        .clk       (clk),
        .rst       (rst),
        .e_en      (e_en),
        .ack_hold  (ack_hold),
        .frame_clk (frame_clk),
        .irq_n     (irq_n)
    );

    // Cumulative enabled ticks since restart, expected frame_clk and irq_n
    localparam int NV = 12;
    localparam int VEC_TICKS [NV] = '{1, 511, 512, 1023, 1024, 1536, 4095, 4096, 4608, 8191, 8192, 12288};
    localparam bit VEC_FRAME [NV] = '{0, 0, 1, 1, 0, 1, 1, 0, 1, 1, 0, 0};
    localparam bit VEC_IRQN  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0};

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic f_exp, input logic i_exp);
        checks++;
        if (frame_clk !== f_exp || irq_n !== i_exp) begin
            errors++;
            $display("FAIL %s: frame_clk=%b irq_n=%b expected frame_clk=%b irq_n=%b",
                     req, frame_clk, irq_n, f_exp, i_exp);
        end
    endtask

    initial begin
        run(3);
        check("R1", 1'b0, 1'b1);
        rst = 1'b0;

        // Table walk: R3 framing edges, R4 request edge, R5 stickiness over wrap
        for (int k = 0; k < NV; k++) begin
            run(VEC_TICKS[k] - ((k == 0) ? 0 : VEC_TICKS[k-1]));
            check((k < 6) ? "R3" : ((k < 8) ? "R4" : "R5"), VEC_FRAME[k], VEC_IRQN[k]);
        end

        // Count is 4096 mod 8192; advance into a framing high phase
        run(600);
        check("R5", 1'b1, 1'b0);

        // R6: acknowledge clears outputs on the next edge and holds them
        ack_hold = 1'b1;
        run(1);
        check("R6", 1'b0, 1'b1);
        run(700);
        check("R6", 1'b0, 1'b1);

        // R7: restart from zero
        ack_hold = 1'b0;
        run(511);
        check("R7", 1'b0, 1'b1);
        run(1);
        check("R7", 1'b1, 1'b1);
        run(3583);
        check("R7", 1'b1, 1'b1);
        run(1);
        check("R7", 1'b0, 1'b0);

        // R2: no advance while the enable is low
        ack_hold = 1'b1;
        run(1);
        ack_hold = 1'b0;
        e_en = 1'b0;
        run(600);
        check("R2", 1'b0, 1'b1);

        // R2: only every other cycle enabled -> 511 ticks after 1022 cycles
        for (int i = 0; i < 1022; i++) begin
            e_en = (i % 2 == 0);
            run(1);
        end
        check("R2", 1'b0, 1'b1);
        for (int i = 0; i < 2; i++) begin
            e_en = (i % 2 == 0);
            run(1);
        end
        check("R2", 1'b1, 1'b1);

        // R6: acknowledge with the enable low still clears
        e_en = 1'b0;
        ack_hold = 1'b1;
        run(1);
        check("R6", 1'b0, 1'b1);
        ack_hold = 1'b0;
        e_en = 1'b1;

        // R1: reset drops a pending request
        run(4096);
        check("R4", 1'b0, 1'b0);
        rst = 1'b1;
        run(1);
        check("R1", 1'b0, 1'b1);
        rst = 1'b0;
        run(512);
        check("R1", 1'b1, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule